// File: doc/BRIEF.md
# Illegal Instruction Exception Classifier

This block sits in the decode stage of a pipeline that runs 16-bit instructions. For every instruction that decode presents, it checks three things: whether the opcode is defined, whether the instruction needs privileged mode while the core is in user mode, and whether the instruction follows a delayed branch. If the instruction may not execute, the block raises an instruction-synchronous exception. The exception is of the re-execution type and comes with a 12-bit code and an address to resume from.

The block remembers across instructions that the previous accepted instruction was a delayed branch. The next valid instruction is then treated as that branch's delay slot. In a delay slot the rules are stricter: any instruction that changes the PC is refused. Every refusal in a slot reports the slot code, not the general code. The saved address points back to the branch, so that the branch and its slot restart together. A pipeline flush squashes the instruction being decoded and forgets any pending slot.

The opcode map used here is the following. Group 0x0 holds exact codes: 0x0008 return-from-subroutine, 0x0009 return-from-exception, 0x000A TLB load and 0x000B sleep. Any other 0x0xxx word is ordinary. Group 0x1 is a control-register move: bits [7:4] select the register (0 = global base, 1 = status register), and bit 8 is 1 for a load and 0 for a store. 0x2xxx is an unconditional delayed branch and 0x3xxx a delayed subroutine call. 0x4xx0 to 0x4xx3 are register jump, register call, relative branch and relative call, all delayed; 0x4xx4 to 0x4xxF are undefined holes. Group 0x5 is a conditional branch: bits [9:8] give 00 branch-if-true, 01 branch-if-false (both without a slot), 10 branch-if-true-delayed and 11 branch-if-false-delayed. 0x6xxx is a trap. 0x7xxx to 0xExxx are ordinary operations. Words from UNDEF_LO to UNDEF_HI (by default 0xF000 to 0xFFFF) are undefined.

Top module: `illegal_insn_classifier`

## Requirements
- R1: While reset is high, and on the first cycle after it, exc_req is 0, exc_code is 0, exc_addr is 0, and no delay slot is pending.
- R2: An undefined word (in the UNDEF_LO..UNDEF_HI range, or 0x4xx4 to 0x4xxF) accepted outside a delay slot sets exc_req for exactly the cycle after the decode strobe. It sets exc_code to 0x180 and exc_addr to that instruction's dec_pc.
- R3: A privileged instruction accepted outside a slot with user_mode = 1 gives code 0x180 and its own address. The privileged instructions are 0x0009, 0x000A, 0x000B, and group 0x1 with bits [7:4] not zero. In privileged mode, and for group 0x1 with bits [7:4] = 0, no exception is raised.
- R4: An undefined word, or a user-mode privileged instruction, accepted in a delay slot gives code 0x1A0.
- R5: A PC-changing instruction accepted in a delay slot gives code 0x1A0. This holds in either mode. PC-changing means 0x0008, 0x0009, every 0x2, 0x3 and 0x6 word, 0x4xx0 to 0x4xx3, every 0x5 word, and a status-register load (group 0x1 with bit 8 = 1 and bits [7:4] = 1).
- R6: Only the delayed set (0x0008, 0x0009, 0x2xxx, 0x3xxx, 0x4xx0 to 0x4xx3, 0x5 with bit 9 = 1) makes the next valid instruction a slot. Cycles without a strobe in between keep the slot pending. A non-delayed branch or trap opens no slot.
- R7: An exception in a slot saves the address of the delayed branch, not the address of the slot instruction.
- R8: flush = 1 with the strobe squashes that instruction, so the output is 0 on the next cycle. flush = 1 on any cycle also cancels a pending slot.
- R9: A delayed branch that itself raises an exception opens no slot.
- R10: When no exception is raised, exc_req, exc_code and exc_addr are all 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode strobe: an instruction is presented |
| dec_insn | input | 16 | Instruction word |
| dec_pc | input | PC_W | Address of the instruction |
| user_mode | input | 1 | 1 = user mode, 0 = privileged mode |
| flush | input | 1 | Pipeline flush |
| exc_req | output | 1 | Exception request, one cycle after the strobe |
| exc_code | output | 12 | 0x180 general, 0x1A0 slot, 0 when idle |
| exc_addr | output | PC_W | Re-execution address |

## Verification
The assertions check, on every cycle, the following properties. A request only ever follows an unflushed strobe. The code always matches whether a slot was pending. A slot exception restores the saved branch address. A flush or an exception always leaves the slot flag clear. Only the bench's scenarios can show the rest: that each opcode class is classified correctly in both modes, both in and out of a slot; that idle gaps keep the slot; and that legal words produce zero outputs. The bench runs a sweep over every pair of representative opcodes and compares the outputs against an arithmetic model.

// File: rtl/iic_pkg.sv
package iic_pkg;

    localparam int INSN_W = 16;
    localparam int CODE_W = 12;
    localparam logic [CODE_W-1:0] CODE_GENERAL = 12'h180;
    localparam logic [CODE_W-1:0] CODE_SLOT    = 12'h1A0;

    typedef struct packed {
        logic undef;     // no defined meaning
        logic priv;      // needs privileged mode
        logic pc_write;  // changes the program counter
        logic delayed;   // next instruction is a delay slot
    } insn_class_t;

    function automatic insn_class_t classify(
        input logic [INSN_W-1:0] w,
        input logic [INSN_W-1:0] lo,
        input logic [INSN_W-1:0] hi
    );
        insn_class_t c;
        c = '0;
        if (w >= lo && w <= hi) begin
            c.undef = 1'b1;
        end else begin
            unique case (w[15:12])
                4'h0: begin
                    c.delayed  = (w[11:0] == 12'h008) || (w[11:0] == 12'h009);
                    c.pc_write = c.delayed;
                    c.priv     = (w[11:0] >= 12'h009) && (w[11:0] <= 12'h00B);
                end
                4'h1: begin
                    c.priv     = (w[7:4] != 4'h0);
                    c.pc_write = w[8] && (w[7:4] == 4'h1);
                end
                4'h2, 4'h3: begin
                    c.delayed  = 1'b1;
                    c.pc_write = 1'b1;
                end
                4'h4: begin
                    c.undef    = (w[3:0] > 4'h3);
                    c.delayed  = !c.undef;
                    c.pc_write = !c.undef;
                end
                4'h5: begin
                    c.pc_write = 1'b1;
                    c.delayed  = w[9];
                end
                4'h6:    c.pc_write = 1'b1;
                default: c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/iic_decode.sv
module iic_decode
    import iic_pkg::*;
#(
    parameter logic [INSN_W-1:0] UNDEF_LO = 16'hF000,
    parameter logic [INSN_W-1:0] UNDEF_HI = 16'hFFFF
) (
    input  logic [INSN_W-1:0] insn,
    output insn_class_t       cls
);
    always_comb cls = classify(insn, UNDEF_LO, UNDEF_HI);

    // a word cannot be both undefined and open a slot
    always_comb begin
        assert (!(cls.undef && cls.delayed)) else $error("undefined word marked delayed (R2)");
    end
endmodule

// File: rtl/iic_slot_track.sv
module iic_slot_track #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,    // strobe without flush
    input  logic            flush,
    input  logic            delayed,
    input  logic            exc_now,
    input  logic [PC_W-1:0] pc_in,
    output logic            slot_active,
    output logic [PC_W-1:0] slot_pc
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            slot_active <= 1'b0;
            slot_pc     <= '0;
        end else if (accept) begin
            slot_active <= delayed && !exc_now;
            slot_pc     <= pc_in;
        end
    end

    p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !slot_active);
    p_exc_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && exc_now) |=> !slot_active);
    p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (!accept && !flush) |=> $stable(slot_active));
endmodule

// File: rtl/illegal_insn_classifier.sv
module illegal_insn_classifier
    import iic_pkg::*;
#(
    parameter int                PC_W     = 32,
    parameter logic [INSN_W-1:0] UNDEF_LO = 16'hF000,
    parameter logic [INSN_W-1:0] UNDEF_HI = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [INSN_W-1:0] dec_insn,
    input  logic [PC_W-1:0]   dec_pc,
    input  logic              user_mode,
    input  logic              flush,
    output logic              exc_req,
    output logic [CODE_W-1:0] exc_code,
    output logic [PC_W-1:0]   exc_addr
);
    insn_class_t     cls;
    logic            accept;
    logic            slot_active;
    logic [PC_W-1:0] slot_pc;
    logic            base_bad;
    logic            exc_now;

    iic_decode #(.UNDEF_LO(UNDEF_LO), .UNDEF_HI(UNDEF_HI)) u_dec (
        .insn (dec_insn),
        .cls  (cls)
    );

    assign accept   = dec_valid && !flush;
    assign base_bad = cls.undef || (cls.priv && user_mode);
    assign exc_now  = accept && (base_bad || (slot_active && cls.pc_write));

    iic_slot_track #(.PC_W(PC_W)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .flush       (flush),
        .delayed     (cls.delayed),
        .exc_now     (exc_now),
        .pc_in       (dec_pc),
        .slot_active (slot_active),
        .slot_pc     (slot_pc)
    );

    always_ff @(posedge clk) begin
        if (rst || !exc_now) begin
            exc_req  <= 1'b0;
            exc_code <= '0;
            exc_addr <= '0;
        end else begin
            exc_req  <= 1'b1;
            exc_code <= slot_active ? CODE_SLOT : CODE_GENERAL;
            exc_addr <= slot_active ? slot_pc : dec_pc;
        end
    end

    p_req_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> ($past(dec_valid) && !$past(flush)));
    p_slot_code_r4: assert property (@(posedge clk) disable iff (rst)
        (exc_req && $past(slot_active)) |-> (exc_code == CODE_SLOT));
    p_general_code_r3: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !$past(slot_active)) |-> (exc_code == CODE_GENERAL && exc_addr == $past(dec_pc)));
    p_slot_addr_r7: assert property (@(posedge clk) disable iff (rst)
        (exc_req && $past(slot_active)) |-> (exc_addr == $past(slot_pc)));
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !exc_req |-> (exc_code == '0 && exc_addr == '0));
    p_flush_squash_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !exc_req);
endmodule

// File: tb/illegal_insn_classifier_test.sv
module illegal_insn_classifier_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 1'b0;
    logic [15:0] dec_insn = '0;
    logic [31:0] dec_pc = '0;
    logic        user_mode = 1'b0;
    logic        flush = 1'b0;
    logic        exc_req;
    logic [11:0] exc_code;
    logic [31:0] exc_addr;

    int checks = 0;
    int fails  = 0;

    // bench model state
    logic        m_slot = 1'b0;
    logic [31:0] m_slot_pc = '0;
    logic        e_req;
    logic [11:0] e_code;
    logic [31:0] e_addr;
    string       e_tag;

    always #5 clk = ~clk;

    illegal_insn_classifier uut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_insn(dec_insn),
        .dec_pc(dec_pc), .user_mode(user_mode), .flush(flush),
        .exc_req(exc_req), .exc_code(exc_code), .exc_addr(exc_addr)
    );

    localparam int NOPS = 22;
    logic [15:0] ops [NOPS] = '{
        16'h0000, 16'h7123, 16'hE555, 16'h0008, 16'h0009, 16'h000A, 16'h000B,
        16'h1000, 16'h1100, 16'h1020, 16'h1110, 16'h2ABC, 16'h3ABC, 16'h4120,
        16'h4121, 16'h4122, 16'h4123, 16'h4125, 16'h5012, 16'h5212, 16'h6033,
        16'hF000
    };

    function automatic bit m_undef(logic [15:0] w);
        return (w >= 16'hF000) || (w[15:12] == 4'h4 && w[3:0] >= 4'h4);
    endfunction
    function automatic bit m_priv(logic [15:0] w);
        if (w == 16'h0009 || w == 16'h000A || w == 16'h000B) return 1;
        return (w[15:12] == 4'h1) && (w[7:4] != 0);
    endfunction
    function automatic bit m_pcw(logic [15:0] w);
        case (w[15:12])
            4'h0: return (w == 16'h0008 || w == 16'h0009);
            4'h1: return (w[8] == 1'b1 && w[7:4] == 4'h1);
            4'h2, 4'h3, 4'h5, 4'h6: return 1;
            4'h4: return w[3:0] < 4'h4;
            default: return 0;
        endcase
    endfunction
    function automatic bit m_dly(logic [15:0] w);
        case (w[15:12])
            4'h0: return (w == 16'h0008 || w == 16'h0009);
            4'h2, 4'h3: return 1;
            4'h4: return w[3:0] < 4'h4;
            4'h5: return w[9];
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model, check at the next negedge
    task automatic step(bit v, logic [15:0] w, logic [31:0] pc, bit um, bit fl);
        bit ex;
        dec_valid = v; dec_insn = w; dec_pc = pc; user_mode = um; flush = fl;
        ex = 0;
        if (v && !fl)
            ex = m_undef(w) || (m_priv(w) && um) || (m_slot && m_pcw(w));
        e_req  = ex;
        e_code = !ex ? 12'h000 : (m_slot ? 12'h1A0 : 12'h180);
        e_addr = !ex ? 32'h0 : (m_slot ? m_slot_pc : pc);
        if (!ex) e_tag = fl ? "R8" : "R10";
        else if (m_slot) e_tag = m_pcw(w) ? "R5" : "R4";
        else e_tag = m_undef(w) ? "R2" : "R3";
        @(posedge clk);
        if (fl) m_slot = 0;
        else if (v) begin
            m_slot = m_dly(w) && !ex;
            m_slot_pc = pc;
        end
        @(negedge clk);
        check(e_tag, 32'(exc_req), 32'(e_req), "req");
        check(e_tag, 32'(exc_code), 32'(e_code), "code");
        check((ex && e_code == 12'h1A0) ? "R7" : e_tag, exc_addr, e_addr, "addr");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 32'(exc_req), 0, "req in reset");
        check("R1", 32'(exc_code), 0, "code in reset");
        rst = 0;
        @(negedge clk);
        check("R1", 32'(exc_req), 0, "req after reset");
        check("R1", exc_addr, 0, "addr after reset");

        // pair sweep: leader then follower, both modes
        for (int um = 0; um < 2; um++)
            for (int a = 0; a < NOPS; a++)
                for (int b = 0; b < NOPS; b++) begin
                    step(1, ops[a], 32'h1000 + 32'(a * 4), um[0], 0);
                    step(1, ops[b], 32'h2000 + 32'(b * 4), um[0], 0);
                    step(0, 16'h0, 32'h0, 0, 1);
                end

        // R6: idle gap keeps slot; slot instruction in slot then BT (non-delayed)
        step(1, 16'h2000, 32'h3000, 0, 0);
        step(0, 16'h0, 32'h0, 0, 0);
        step(0, 16'h0, 32'h0, 0, 0);
        step(1, 16'hF123, 32'h3004, 0, 0);
        check("R6", exc_addr, 32'h3000, "slot after gap addr");
        step(1, 16'h5012, 32'h3100, 0, 0);
        step(1, 16'h6000, 32'h3102, 0, 0);
        check("R6", 32'(exc_req), 0, "no slot after plain branch");

        // R8: flush on same cycle as slot instruction, then illegal
        step(1, 16'h3000, 32'h4000, 1, 0);
        step(1, 16'hF000, 32'h4002, 1, 1);
        check("R8", 32'(exc_req), 0, "squashed");
        step(1, 16'h2000, 32'h4004, 1, 0);
        check("R8", 32'(exc_req), 0, "slot cleared by flush");

        // R9: user RTE raises exception and opens no slot
        step(0, 16'h0, 32'h0, 0, 1);
        step(1, 16'h0009, 32'h5000, 1, 0);
        step(1, 16'h6000, 32'h5002, 1, 0);
        check("R9", 32'(exc_req), 0, "no slot after refused branch");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule